// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block takes one in-phase word and one quadrature word for each sample, both conversion results of `W` bits, and places them on two registered output buses. A bus-mode input picks between parallel presentation, with each channel on its own bus, and time-multiplexed presentation. In multiplexed mode both channels share the I bus and the Q bus is held at zero. A number-format input picks straight offset binary or two's complement. A single indicator output marks new data in parallel mode and marks the channel phase in multiplexed mode.

In multiplexed mode one accepted sample becomes two output words on consecutive clocks, with the I word first. The source must therefore present samples no faster than every other clock to keep every Q word. Format selection is sampled together with the sample's valid strobe, so both words of a pair share one encoding.

Top module: `iqfmt_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_i` and `out_q` are all zeros and `out_flag` is low.
- R2: In parallel mode (`par_sel`=1), a sample accepted with `in_valid` at a rising edge appears after that edge on `out_i` (I word) and `out_q` (Q word) together, and `out_flag` is high.
- R3: In parallel mode, after an edge with `in_valid` low, `out_flag` is low and both buses keep their previous values.
- R4: In multiplexed mode (`par_sel`=0), an accepted sample drives its I word on `out_i` with `out_flag` high after the accepting edge. If no new sample arrives, its Q word follows on `out_i` with `out_flag` low after the next edge.
- R5: After every edge taken in multiplexed mode, all bits of `out_q` are zero.
- R6: In multiplexed mode, once the Q word has been shown and no sample arrives, `out_i` holds and `out_flag` stays low.
- R7: In multiplexed mode, a sample accepted on the edge right after another sample replaces the pending Q word. The new I word is shown with `out_flag` high, then the new Q word follows, and the earlier Q word is never shown.
- R8: With `fmt_tc`=0 words pass unchanged. With `fmt_tc`=1 bit W-1 (the MSB; bit 0 is the LSB) is inverted and the other bits pass unchanged, e.g. 0x000→0x200 and 0x3FF→0x1FF for W=10.
- R9: Both words of a multiplexed pair use the `fmt_tc` value sampled with that pair's `in_valid`, even if `fmt_tc` changes before the Q word is shown.
- R10: Switching to parallel mode while a multiplexed Q word is still pending discards that word. With no new sample, `out_i` holds the I word and `out_flag` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | W | Raw in-phase conversion word (offset binary) |
| in_q | input | W | Raw quadrature conversion word (offset binary) |
| in_valid | input | 1 | High when `in_i`/`in_q` carry a new sample |
| par_sel | input | 1 | 1 = parallel buses, 0 = multiplexed onto `out_i` |
| fmt_tc | input | 1 | 0 = offset binary, 1 = two's complement |
| out_i | output | W | I bus (also carries Q words in multiplexed mode) |
| out_q | output | W | Q bus (zero in multiplexed mode) |
| out_flag | output | 1 | Data-valid strobe (parallel) or I-phase marker (multiplexed) |

## Verification
In multiplexed mode, emitting a pending Q word can fall in the same cycle as accepting a fresh sample. The new sample must win, and the stale Q word must never appear. The bench provokes this by asserting `in_valid` on two consecutive edges. It then checks that the second I word follows the first directly with the indicator still high, and that the second Q word comes after it. A second collision is a format change landing between the two words of a pair. It is judged by checking that the Q word carries the encoding chosen when the pair was accepted.

// File: rtl/iqfmt_pkg.sv
package iqfmt_pkg;

    localparam int DATA_W = 10;
    localparam int N_CH   = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;

    typedef enum logic {
        BUS_MUX = 1'b0,
        BUS_PAR = 1'b1
    } bus_mode_e;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } num_fmt_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_Q_DUE = 1'b1
    } mux_phase_e;

    function automatic logic msb_flip(num_fmt_e f);
        return (f == FMT_TWOS);
    endfunction

endpackage

// File: rtl/iqfmt_encode.sv
module iqfmt_encode
    import iqfmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  num_fmt_e       fmt,
    input  logic [W-1:0]   raw,
    output logic [W-1:0]   enc
);

    localparam int MSB = W - 1;

    logic flip;
    assign flip = msb_flip(fmt);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == MSB) begin : g_msb
            assign enc[b] = raw[b] ^ flip;
        end else begin : g_low
            assign enc[b] = raw[b];
        end
    end

endmodule

// File: rtl/iqfmt_seq.sv
module iqfmt_seq
    import iqfmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  bus_mode_e      mode,
    input  logic           in_valid,
    input  logic [W-1:0]   enc_i,
    input  logic [W-1:0]   enc_q,
    output logic           i_we,
    output logic           q_we,
    output logic           flag_we,
    output logic [W-1:0]   nxt_i,
    output logic [W-1:0]   nxt_q,
    output logic           nxt_flag
);

    mux_phase_e   phase_r, phase_n;
    logic [W-1:0] pend_q_r, pend_q_n;

    always_comb begin
        phase_n  = phase_r;
        pend_q_n = pend_q_r;
        i_we     = 1'b0;
        q_we     = 1'b0;
        flag_we  = 1'b0;
        nxt_i    = enc_i;
        nxt_q    = enc_q;
        nxt_flag = 1'b0;
        if (mode == BUS_PAR) begin
            phase_n  = PH_IDLE;
            i_we     = in_valid;
            q_we     = in_valid;
            flag_we  = 1'b1;
            nxt_flag = in_valid;
        end else begin
            q_we  = 1'b1;
            nxt_q = '0;
            if (in_valid) begin
                i_we     = 1'b1;
                flag_we  = 1'b1;
                nxt_i    = enc_i;
                nxt_flag = 1'b1;
                pend_q_n = enc_q;
                phase_n  = PH_Q_DUE;
            end else if (phase_r == PH_Q_DUE) begin
                i_we     = 1'b1;
                flag_we  = 1'b1;
                nxt_i    = pend_q_r;
                nxt_flag = 1'b0;
                phase_n  = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_r  <= PH_IDLE;
            pend_q_r <= '0;
        end else begin
            phase_r  <= phase_n;
            pend_q_r <= pend_q_n;
        end
    end

endmodule

// File: rtl/iqfmt_outreg.sv
module iqfmt_outreg
    import iqfmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           i_we,
    input  logic           q_we,
    input  logic           flag_we,
    input  logic [W-1:0]   nxt_i,
    input  logic [W-1:0]   nxt_q,
    input  logic           nxt_flag,
    output logic [W-1:0]   bus_i,
    output logic [W-1:0]   bus_q,
    output logic           flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_i <= '0;
            bus_q <= '0;
            flag  <= 1'b0;
        end else begin
            if (i_we)    bus_i <= nxt_i;
            if (q_we)    bus_q <= nxt_q;
            if (flag_we) flag  <= nxt_flag;
        end
    end

endmodule

// File: rtl/iqfmt_top.sv
module iqfmt_top
    import iqfmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   in_i,
    input  logic [W-1:0]   in_q,
    input  logic           in_valid,
    input  logic           par_sel,
    input  logic           fmt_tc,
    output logic [W-1:0]   out_i,
    output logic [W-1:0]   out_q,
    output logic           out_flag
);

    bus_mode_e    mode;
    num_fmt_e     fmt;
    logic [W-1:0] raw [N_CH];
    logic [W-1:0] enc [N_CH];

    assign mode      = bus_mode_e'(par_sel);
    assign fmt       = num_fmt_e'(fmt_tc);
    assign raw[CH_I] = in_i;
    assign raw[CH_Q] = in_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        iqfmt_encode #(.W(W)) u_enc (
            .fmt (fmt),
            .raw (raw[c]),
            .enc (enc[c])
        );
    end

    logic           i_we, q_we, flag_we, nxt_flag;
    logic [W-1:0]   nxt_i, nxt_q;

    iqfmt_seq #(.W(W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .in_valid (in_valid),
        .enc_i    (enc[CH_I]),
        .enc_q    (enc[CH_Q]),
        .i_we     (i_we),
        .q_we     (q_we),
        .flag_we  (flag_we),
        .nxt_i    (nxt_i),
        .nxt_q    (nxt_q),
        .nxt_flag (nxt_flag)
    );

    iqfmt_outreg #(.W(W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .i_we     (i_we),
        .q_we     (q_we),
        .flag_we  (flag_we),
        .nxt_i    (nxt_i),
        .nxt_q    (nxt_q),
        .nxt_flag (nxt_flag),
        .bus_i    (out_i),
        .bus_q    (out_q),
        .flag     (out_flag)
    );

endmodule

// File: rtl/iqfmt_chk.sv
module iqfmt_chk #(
    parameter int W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic [W-1:0]   in_i,
    input logic [W-1:0]   in_q,
    input logic           in_valid,
    input logic           par_sel,
    input logic           fmt_tc,
    input logic [W-1:0]   out_i,
    input logic [W-1:0]   out_q,
    input logic           out_flag
);

    function automatic logic [W-1:0] expect_enc(logic [W-1:0] x, logic tc);
        return tc ? {~x[W-1], x[W-2:0]} : x;
    endfunction

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_i == '0 && out_q == '0 && !out_flag));

    p_par_load_r2: assert property (@(posedge clk) disable iff (rst)
        (par_sel && in_valid) |=> (out_flag &&
            out_i == $past(expect_enc(in_i, fmt_tc)) &&
            out_q == $past(expect_enc(in_q, fmt_tc))));

    p_par_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (par_sel && !in_valid) |=> (!out_flag && $stable(out_i) && $stable(out_q)));

    p_mux_i_first_r4: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && in_valid) |=> (out_flag && out_i == $past(expect_enc(in_i, fmt_tc))));

    p_mux_q_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && !in_valid && $past(!par_sel && in_valid)) |=> !out_flag);

    p_mux_q_low_r5: assert property (@(posedge clk) disable iff (rst)
        !par_sel |=> (out_q == '0));

endmodule

bind iqfmt_top iqfmt_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_i     (in_i),
    .in_q     (in_q),
    .in_valid (in_valid),
    .par_sel  (par_sel),
    .fmt_tc   (fmt_tc),
    .out_i    (out_i),
    .out_q    (out_q),
    .out_flag (out_flag)
);

// File: tb/iqfmt_top_tb.sv
module iqfmt_top_tb;

    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic         in_valid = 1'b0;
    logic         par_sel = 1'b1;
    logic         fmt_tc = 1'b0;
    logic [W-1:0] out_i, out_q;
    logic         out_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    iqfmt_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .in_i(in_i), .in_q(in_q), .in_valid(in_valid),
        .par_sel(par_sel), .fmt_tc(fmt_tc),
        .out_i(out_i), .out_q(out_q), .out_flag(out_flag)
    );

    function automatic logic [W-1:0] enc(logic [W-1:0] x, logic tc);
        return tc ? {~x[W-1], x[W-2:0]} : x;
    endfunction

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(logic v, logic [W-1:0] i, logic [W-1:0] q);
        in_valid = v;
        in_i     = i;
        in_q     = q;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        put(0, '0, '0);
        step(); step();
        chk("R1", "out_i in reset", out_i, '0);
        chk("R1", "out_q in reset", out_q, '0);
        chk("R1", "flag in reset", {9'b0, out_flag}, '0);
        rst = 1'b0;
        step();
        chk("R1", "out_i after reset", out_i, '0);
        chk("R1", "flag after reset", {9'b0, out_flag}, '0);
    endtask

    task automatic t_parallel();
        par_sel = 1'b1; fmt_tc = 1'b0;
        put(1, 10'h155, 10'h2AA);
        step();
        chk("R2", "par out_i", out_i, 10'h155);
        chk("R2", "par out_q", out_q, 10'h2AA);
        chk("R2", "par flag", {9'b0, out_flag}, 10'h1);
        fmt_tc = 1'b1;
        put(1, 10'h000, 10'h3FF);
        step();
        chk("R8", "tc out_i", out_i, enc(10'h000, 1'b1));
        chk("R8", "tc out_q", out_q, 10'h1FF);
        put(0, 10'h0AB, 10'h0CD);
        step();
        chk("R3", "idle flag", {9'b0, out_flag}, 10'h0);
        chk("R3", "idle out_i hold", out_i, 10'h200);
        chk("R3", "idle out_q hold", out_q, 10'h1FF);
        fmt_tc = 1'b0;
    endtask

    task automatic t_mux_pair();
        par_sel = 1'b0; fmt_tc = 1'b0;
        put(1, 10'h123, 10'h0F0);
        step();
        chk("R4", "mux I word", out_i, 10'h123);
        chk("R4", "mux I flag", {9'b0, out_flag}, 10'h1);
        chk("R5", "mux out_q zero", out_q, 10'h000);
        put(0, 10'h3C3, 10'h3C3);
        step();
        chk("R4", "mux Q word", out_i, 10'h0F0);
        chk("R4", "mux Q flag", {9'b0, out_flag}, 10'h0);
        chk("R5", "mux out_q zero 2", out_q, 10'h000);
        step();
        chk("R6", "mux idle hold", out_i, 10'h0F0);
        chk("R6", "mux idle flag", {9'b0, out_flag}, 10'h0);
    endtask

    task automatic t_fmt_capture();
        par_sel = 1'b0; fmt_tc = 1'b1;
        put(1, 10'h010, 10'h020);
        step();
        chk("R9", "I word tc", out_i, 10'h210);
        fmt_tc = 1'b0;
        put(0, '0, '0);
        step();
        chk("R9", "Q keeps capture fmt", out_i, 10'h220);
    endtask

    task automatic t_back_to_back();
        par_sel = 1'b0; fmt_tc = 1'b0;
        put(1, 10'h001, 10'h002);
        step();
        chk("R7", "first I", out_i, 10'h001);
        put(1, 10'h003, 10'h004);
        step();
        chk("R7", "second I replaces Q", out_i, 10'h003);
        chk("R7", "flag stays high", {9'b0, out_flag}, 10'h1);
        put(0, '0, '0);
        step();
        chk("R7", "second Q", out_i, 10'h004);
        chk("R7", "second Q flag", {9'b0, out_flag}, 10'h0);
    endtask

    task automatic t_mode_switch();
        par_sel = 1'b0; fmt_tc = 1'b0;
        put(1, 10'h111, 10'h222);
        step();
        chk("R10", "I before switch", out_i, 10'h111);
        par_sel = 1'b1;
        put(0, '0, '0);
        step();
        chk("R10", "pending Q dropped", out_i, 10'h111);
        chk("R10", "flag low after switch", {9'b0, out_flag}, 10'h0);
        chk("R10", "out_q held", out_q, 10'h000);
        step();
        chk("R10", "still no Q word", out_i, 10'h111);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_mux_pair();
        t_fmt_capture();
        t_back_to_back();
        t_mode_switch();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule